// File: doc/BRIEF.md
# Virtual Edge Unit Spill/Restore Sequencer

This block drives one interface unit on the edge of a two-dimensional compute array when that unit is borrowed as a virtual unit. A tile grid can be larger than the physical array, so it runs in several passes. An edge unit with no tile work in a pass must then carry buffer contents across the pass boundary. On the north or west edge it restores: it loads a saved buffer image from memory into its neighbour buffer. On the south or east edge it spills: it writes that buffer out to memory. The runtime sets a virtual-mode bit and an edge direction before every pass and pulses `pass_start`.

The sequencer works in lock-step with the array-wide barrier. A restoring unit moves data first and then joins the barrier. A spilling unit joins the barrier first and then moves data. Each loop iteration is one time step, and the loop runs until the runtime raises `pass_done`. Moving data means one start pulse to an external memory engine, followed by a wait for its done signal. Until a loading unit has begun computing (`compute_started`), the sequencer still joins every barrier but moves no data, so no dummy transfers occur. With virtual mode clear, the barrier request of the normal unit passes straight through.

Top module: `edge_vunit_seq`

## Requirements
- R1: In reset `xfer_start` and `active` are 0, and `bar_arrive` equals `norm_arrive`.
- R2: After a `pass_start` with `virt_en`=0, `active` stays 0, no `xfer_start` is issued, and `bar_arrive` equals `norm_arrive` in the same cycle.
- R3: The edge code is 0=north, 1=east, 2=south, 3=west. East and south give a spilling unit (`xfer_spill`=1). North and west give a restoring unit (`xfer_spill`=0).
- R4: A restoring unit repeats this loop: one transfer, then one barrier.
- R5: A spilling unit repeats this loop: one barrier, then one transfer.
- R6: `xfer_start` lasts exactly one cycle. After it, no new `xfer_start` and no `bar_arrive` occur until `xfer_done` has been seen.
- R7: Once raised in virtual mode, `bar_arrive` stays high until a cycle with `bar_release`=1.
- R8: Until `compute_started` has been seen since the last `pass_start`, no transfer is issued, but every barrier is still taken.
- R9: A restoring unit transfers in the first iteration that begins with the start flag seen. A spilling unit transfers right after the barrier at whose release the flag is seen.
- R10: `pass_done` is sampled at the end of each iteration. When it is 1, the unit stops, `active` falls, and no further transfers or barrier requests follow.
- R11: Every `pass_start` latches the role again, clears the remembered start flag and restarts the loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pass_start | input | 1 | Pulse: new pass, latch role |
| virt_en | input | 1 | Act as virtual unit this pass |
| edge_dir | input | 2 | Edge code (0 N, 1 E, 2 S, 3 W) |
| compute_started | input | 1 | A loading unit has begun computing |
| pass_done | input | 1 | All tiles of the pass have finished |
| norm_arrive | input | 1 | Barrier request of the normal unit |
| bar_arrive | output | 1 | Barrier request to the array |
| bar_release | input | 1 | Barrier release pulse |
| xfer_start | output | 1 | One-cycle transfer command |
| xfer_spill | output | 1 | 1 = buffer to memory, 0 = memory to buffer |
| xfer_done | input | 1 | Memory engine finished the transfer |
| active | output | 1 | Virtual loop running |

## Verification
The bench builds the block with its default spill mask (east and south), so all four edge codes reach both roles. An automatic memory engine answers each transfer after three cycles, and an automatic barrier releases after two cycles of request. These delays bring within reach the wait for a transfer, the held barrier request, and the start flag arriving at the same edge as a release. The bench varies the release index at which the start flag rises and the one at which the pass ends. This covers passes that are ungated, passes gated part-way, and passes never started.

// File: rtl/evs_pkg.sv
package evs_pkg;
  localparam int EDGE_W  = 2;
  localparam int NUM_DIR = 1 << EDGE_W;

  typedef enum logic [EDGE_W-1:0] {
    EDGE_NORTH = 2'd0,
    EDGE_EAST  = 2'd1,
    EDGE_SOUTH = 2'd2,
    EDGE_WEST  = 2'd3
  } edge_code_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_TOP   = 3'd1,
    ST_ISSUE = 3'd2,
    ST_WAIT  = 3'd3,
    ST_SYNC  = 3'd4
  } seq_state_e;
endpackage

// File: rtl/evs_role.sv
module evs_role
  import evs_pkg::*;
#(
  parameter logic [NUM_DIR-1:0] SPILL_MASK = 4'b0110
) (
  input  logic [EDGE_W-1:0] edge_i,
  output logic              spill_o
);
  logic [NUM_DIR-1:0] hit;

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    assign hit[d] = SPILL_MASK[d] && (edge_i == EDGE_W'(d));
  end

  assign spill_o = |hit;
endmodule

// File: rtl/evs_gate.sv
module evs_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic flag_i,
  output logic started_o
);
  logic seen_q;
  logic seen_d;

  always_comb begin
    if (clr_i) seen_d = 1'b0;
    else       seen_d = seen_q | flag_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= seen_d;
  end

  assign started_o = seen_q | flag_i;
endmodule

// File: rtl/evs_fsm.sv
module evs_fsm
  import evs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pass_start,
  input  logic virt_en,
  input  logic spill_dec,
  input  logic started,
  input  logic pass_done,
  input  logic xfer_done,
  input  logic bar_release,
  input  logic norm_arrive,
  output logic bar_arrive,
  output logic xfer_start,
  output logic xfer_spill,
  output logic active,
  output logic virt_mode
);
  seq_state_e st_q, st_d, loop_next;
  logic virt_q, spill_q;
  logic role_en;

  assign role_en = pass_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      virt_q  <= 1'b0;
      spill_q <= 1'b0;
    end else if (role_en) begin
      virt_q  <= virt_en;
      spill_q <= spill_dec & virt_en;
    end
  end

  always_comb begin
    if (pass_done) loop_next = ST_IDLE;
    else           loop_next = ST_TOP;
  end

  always_comb begin
    st_d = st_q;
    if (pass_start) begin
      st_d = virt_en ? ST_TOP : ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE:  st_d = ST_IDLE;
        ST_TOP: begin
          if (spill_q)      st_d = ST_SYNC;
          else if (started) st_d = ST_ISSUE;
          else              st_d = ST_SYNC;
        end
        ST_ISSUE: st_d = ST_WAIT;
        ST_WAIT: begin
          if (xfer_done) st_d = spill_q ? loop_next : ST_SYNC;
        end
        ST_SYNC: begin
          if (bar_release) begin
            if (spill_q && started) st_d = ST_ISSUE;
            else                    st_d = loop_next;
          end
        end
        default:  st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign xfer_start = (st_q == ST_ISSUE);
  assign xfer_spill = spill_q;
  assign active     = (st_q != ST_IDLE);
  assign bar_arrive = virt_q ? (st_q == ST_SYNC) : norm_arrive;
  assign virt_mode  = virt_q;
endmodule

// File: rtl/edge_vunit_seq.sv
module edge_vunit_seq
  import evs_pkg::*;
#(
  parameter logic [NUM_DIR-1:0] SPILL_MASK = 4'b0110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pass_start,
  input  logic              virt_en,
  input  logic [EDGE_W-1:0] edge_dir,
  input  logic              compute_started,
  input  logic              pass_done,
  input  logic              norm_arrive,
  output logic              bar_arrive,
  input  logic              bar_release,
  output logic              xfer_start,
  output logic              xfer_spill,
  input  logic              xfer_done,
  output logic              active
);
  logic spill_dec_w;
  logic started_w;
  logic virt_mode_w;

  evs_role #(.SPILL_MASK(SPILL_MASK)) u_role (
    .edge_i  (edge_dir),
    .spill_o (spill_dec_w)
  );

  evs_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (pass_start),
    .flag_i    (compute_started),
    .started_o (started_w)
  );

  evs_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .pass_start  (pass_start),
    .virt_en     (virt_en),
    .spill_dec   (spill_dec_w),
    .started     (started_w),
    .pass_done   (pass_done),
    .xfer_done   (xfer_done),
    .bar_release (bar_release),
    .norm_arrive (norm_arrive),
    .bar_arrive  (bar_arrive),
    .xfer_start  (xfer_start),
    .xfer_spill  (xfer_spill),
    .active      (active),
    .virt_mode   (virt_mode_w)
  );
endmodule

// File: rtl/evs_checker.sv
module evs_checker (
  input logic clk,
  input logic rst_n,
  input logic pass_start,
  input logic virt_mode,
  input logic started,
  input logic bar_arrive,
  input logic bar_release,
  input logic xfer_start,
  input logic active
);
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start); // R6

  AST_NO_START_WITH_ARRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> !bar_arrive); // R6

  AST_NO_XFER_UNSTARTED: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> started); // R8

  AST_NO_XFER_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    !virt_mode |-> !xfer_start); // R2

  AST_ARRIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (virt_mode && bar_arrive && !bar_release && !pass_start) |=> bar_arrive); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (virt_mode && !active) |-> (!bar_arrive && !xfer_start)); // R10
endmodule

bind edge_vunit_seq evs_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pass_start  (pass_start),
  .virt_mode   (virt_mode_w),
  .started     (started_w),
  .bar_arrive  (bar_arrive),
  .bar_release (bar_release),
  .xfer_start  (xfer_start),
  .active      (active)
);

// File: tb/sim_edge_vunit_seq.sv
`timescale 1ns/1ps
module sim_edge_vunit_seq;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n;
  logic       pass_start, virt_en, compute_started, pass_done, norm_arrive;
  logic [1:0] edge_dir;
  logic       bar_arrive, bar_release, xfer_start, xfer_spill, xfer_done, active;

  edge_vunit_seq u0 (
    .clk(clk), .rst_n(rst_n), .pass_start(pass_start), .virt_en(virt_en),
    .edge_dir(edge_dir), .compute_started(compute_started), .pass_done(pass_done),
    .norm_arrive(norm_arrive), .bar_arrive(bar_arrive), .bar_release(bar_release),
    .xfer_start(xfer_start), .xfer_spill(xfer_spill), .xfer_done(xfer_done),
    .active(active)
  );

  // request variables written by the stimulus task, read by the environment
  int    go_tok = 0;
  int    tb_j = 0, tb_k = 0;
  bit    tb_virt = 0, tb_spill = 0;
  // environment state
  int    seen_tok = 0;
  int    mcnt = 0, bcnt = 0, rel_cnt = 0;
  bit    vmode = 0, exp_spill = 0, prev_x = 0, prev_arr = 0;
  string evs = "";
  int    p_checks = 0, p_errs = 0;
  int    checks = 0, errors = 0;

  // environment: protocol checks, event log, memory engine, barrier, pass control
  always @(negedge clk) begin
    if (rst_n && vmode) begin
      p_checks++;
      if (xfer_start && prev_x) begin
        p_errs++; $display("FAIL R6 xfer_start held: actual 1 expected 0");
      end
      if ((bar_arrive || xfer_start) && mcnt > 0) begin
        p_errs++; $display("FAIL R6 activity while transfer pending: actual arrive=%0b start=%0b expected 0 0", bar_arrive, xfer_start);
      end
      if (prev_arr && !bar_arrive && !bar_release) begin
        p_errs++; $display("FAIL R7 arrive dropped without release: actual 0 expected 1");
      end
      if (xfer_start && (xfer_spill != exp_spill)) begin
        p_errs++; $display("FAIL R3 xfer_spill: actual %0b expected %0b", xfer_spill, exp_spill);
      end
    end
    if (rst_n && xfer_start) evs = {evs, "X"};
    if (rst_n && bar_arrive && !prev_arr) evs = {evs, "B"};
    prev_x   = xfer_start;
    prev_arr = bar_arrive;

    xfer_done = 1'b0;
    if (xfer_start) mcnt = 3;
    else if (mcnt > 0) begin
      mcnt--;
      if (mcnt == 0) xfer_done = 1'b1;
    end

    if (bar_release) begin
      bar_release = 1'b0; bcnt = 0;
    end else if (bar_arrive) begin
      bcnt++;
      if (bcnt >= 2) begin
        bar_release = 1'b1; bcnt = 0; rel_cnt++;
        if (rel_cnt == tb_j) compute_started = 1'b1;
        if (rel_cnt == tb_k) pass_done = 1'b1;
      end
    end

    pass_start = 1'b0;
    if (go_tok != seen_tok) begin
      seen_tok        = go_tok;
      pass_start      = 1'b1;
      compute_started = (tb_j == 0);
      pass_done       = 1'b0;
      rel_cnt         = 0;
      evs             = "";
      vmode           = tb_virt;
      exp_spill       = tb_spill;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input string act, input string exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %s expected %s", req, what, act, exp);
    end
  endtask

  task automatic launch(input bit v, input int dir, input int j, input int k);
    @(posedge clk); #2;
    virt_en  = v;
    edge_dir = 2'(dir);
    tb_j = j; tb_k = k; tb_virt = v;
    tb_spill = (dir == 1) || (dir == 2);
    go_tok++;
    @(negedge clk);   // environment pulses pass_start here
    @(negedge clk);   // role latched at the edge between
  endtask

  task automatic run_vpass(input int dir, input int j, input int k, input string req);
    string exp = "";
    bit    spill = (dir == 1) || (dir == 2);
    int    n = 0;
    for (int i = 1; i <= k; i++) begin
      if (spill) begin
        exp = {exp, "B"};
        if (j == 0 || i >= j) exp = {exp, "X"};
      end else begin
        if (i > j) exp = {exp, "X"};
        exp = {exp, "B"};
      end
    end
    launch(1'b1, dir, j, k);
    check(active == 1'b1, "R11", "active after pass_start", $sformatf("%0b", active), "1");
    while (active && n < 3000) begin @(negedge clk); n++; end
    check(n < 3000, req, "pass did not finish", $sformatf("%0d", n), "<3000");
    repeat (8) @(negedge clk);
    #1;
    check(evs == exp, req, $sformatf("event order edge %0d start@%0d end@%0d", dir, j, k), evs, exp);
    check(!active && !xfer_start && !bar_arrive, "R10", "quiet after pass end",
          $sformatf("%0b%0b%0b", active, xfer_start, bar_arrive), "000");
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired: actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks + p_checks + 1, errors + p_errs + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pass_start = 1'b0; virt_en = 1'b0; edge_dir = 2'd0;
    compute_started = 1'b0; pass_done = 1'b0; norm_arrive = 1'b1;
    bar_release = 1'b0; xfer_done = 1'b0;
    repeat (3) @(negedge clk);
    check(!xfer_start && !active, "R1", "outputs in reset", $sformatf("%0b%0b", xfer_start, active), "00");
    check(bar_arrive == 1'b1, "R1", "arrive passthrough in reset", $sformatf("%0b", bar_arrive), "1");
    norm_arrive = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // restore, ungated, north
    run_vpass(0, 0, 3, "R4");
    // normal pass after a virtual one
    launch(1'b0, 0, 0, 1);
    check(active == 1'b0, "R2", "active in normal pass", $sformatf("%0b", active), "0");
    norm_arrive = 1'b1; #1;
    check(bar_arrive == 1'b1, "R2", "arrive follows normal high", $sformatf("%0b", bar_arrive), "1");
    @(negedge clk); norm_arrive = 1'b0; #1;
    check(bar_arrive == 1'b0, "R2", "arrive follows normal low", $sformatf("%0b", bar_arrive), "0");
    repeat (6) @(negedge clk); #1;
    check(evs == "B", "R2", "no transfer in normal pass", evs, "B");
    // spill, ungated, south
    run_vpass(2, 0, 3, "R5");
    // restore, gated until second release, west (also start memory cleared)
    run_vpass(3, 2, 4, "R9");
    // spill, gated until second release, east
    run_vpass(1, 2, 4, "R9");
    // restore never started
    run_vpass(0, 5, 3, "R8");
    // spill never started
    run_vpass(2, 9, 2, "R8");
    // spill started at first release, single iteration
    run_vpass(1, 1, 1, "R5");
    // restore again after spill passes: role relatched
    run_vpass(3, 0, 2, "R11");

    $display("CHECKS %0d ERRORS %0d", checks + p_checks, errors + p_errs);
    $finish;
  end
endmodule